// File: doc/BRIEF.md
# Peripheral Interrupt Flag Aggregator

This block gathers the per-source interrupt flags of one peripheral and reduces them to a single request line. A one-cycle pulse on any source input latches that source's flag. Each flag is gated by its own mask bit, and the gated flags are ORed into `per_irq`. A second stage then latches `per_irq` into a pending bit. That bit is gated by a core-side enable to produce `core_irq`.

Software reaches the block through a small 32-bit register port. It can read the raw flags and set or clear flags with write-one semantics. It can program the mask, set or clear the pending bit, and set or clear the core-side enable. Writes take effect in one cycle. Reads return data in the cycle after the read strobe.

Register addresses (`reg_addr`):
- 0 reads the raw flags and ignores writes.
- 1 is flag-set.
- 2 is flag-clear.
- 3 is the mask.
- 4 is pending control.

Top module: `irq_aggregator`

## Requirements
- R1: A high on `src_evt[i]` at a clock edge sets flag i. The flag stays set until software clears it.
- R2: A write to address 1 sets every flag whose `reg_wdata` bit is one. Zero bits, and bits at or above N_SRC, leave flags unchanged.
- R3: A write to address 2 clears every flag whose `reg_wdata` bit is one. Zero bits leave flags unchanged.
- R4: When `src_evt[i]` and a flag-clear of bit i arrive in the same cycle, flag i ends up set.
- R5: Address 3 holds the read/write mask. `per_irq` is high exactly when some flag and its mask bit are both one.
- R6: At every clock edge where `per_irq` is high and no pending-clear is written, the pending bit becomes one.
- R7: A write to address 4 sets pending with bit 0 and clears it with bit 1. A clear beats both a set and a high `per_irq` in that cycle. If `per_irq` is still high, pending sets again one cycle later.
- R8: A write to address 4 sets the core enable with bit 2 and clears it with bit 3. A clear beats a set. `core_irq` is high exactly when pending and core enable are both one.
- R9: Synchronous active-high reset zeroes all flags, the mask, pending, the core enable and `reg_rdata`.
- R10: A read strobe loads `reg_rdata` at the next edge with one of the following:
  - the raw flags (unmasked) for address 0;
  - the mask for address 3;
  - pending in bit 0 and core enable in bit 1 for address 4;
  - zero for any other address.
  Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | N_SRC | Hardware event pulses, one per flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| per_irq | output | 1 | OR of masked flags |
| core_irq | output | 1 | Pending AND core enable |

## Verification
The bench first steps a table of set, clear, zero-data and read-only-address writes, comparing the raw flag word after each. It then targets the following corner cases:
- A hardware event colliding with a software clear. A design where the clear wins would lose the event.
- The one-cycle latency from request to pending to core request. An off-by-one pipeline would assert `core_irq` a cycle early or late.
- A pending clear issued while the request is still high. A design that let the request win would never show the one-cycle drop. One that failed to re-latch would drop the interrupt for good.
- Masked flags, which must still read back raw. A design returning masked flags would hide them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_SET   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PCTL  = 3'd4;

  // bit positions inside the pending-control word
  localparam int PB_SET  = 0;
  localparam int PB_CLR  = 1;
  localparam int PB_ESET = 2;
  localparam int PB_ECLR = 3;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic mask_wr,
  input  logic mask_val,
  output logic flag_q,
  output logic mask_q,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      // hardware set has priority over software clear
      flag_q <= hw_set | sw_set | (flag_q & ~sw_clr);
      if (mask_wr) mask_q <= mask_val;
    end
  end

  assign req = flag_q & mask_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> flag_q); // R4

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !sw_clr) |=> flag_q); // R1

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !hw_set && !sw_set) |=> !flag_q); // R3
endmodule

// File: rtl/irq_pend_stage.sv
module irq_pend_stage (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic pend_set,
  input  logic pend_clr,
  input  logic en_set,
  input  logic en_clr,
  output logic pend_q,
  output logic en_q,
  output logic core_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (pend_clr) pend_q <= 1'b0;
      else          pend_q <= pend_q | req_in | pend_set;
      if (en_clr)   en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
    end
  end

  assign core_irq = pend_q & en_q;

  AST_PEND_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_in && !pend_clr) |=> pend_q); // R6

  AST_PEND_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    pend_clr |=> !pend_q); // R7

  AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    en_clr |=> !en_q); // R8
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_SRC-1:0]                  src_evt,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [irq_agg_pkg::ADDR_W-1:0]    reg_addr,
  input  logic [irq_agg_pkg::REG_W-1:0]     reg_wdata,
  output logic [irq_agg_pkg::REG_W-1:0]     reg_rdata,
  output logic                              per_irq,
  output logic                              core_irq
);
  import irq_agg_pkg::*;

  localparam int PAD_W = REG_W - N_SRC;

  logic [N_SRC-1:0] flags, masks, reqs;
  logic wr_set, wr_clr, wr_mask, wr_pctl;
  logic pend_q, en_q;

  assign wr_set  = reg_wr && (reg_addr == A_SET);
  assign wr_clr  = reg_wr && (reg_addr == A_CLR);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_pctl = reg_wr && (reg_addr == A_PCTL);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    irq_flag_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (src_evt[i]),
      .sw_set  (wr_set & reg_wdata[i]),
      .sw_clr  (wr_clr & reg_wdata[i]),
      .mask_wr (wr_mask),
      .mask_val(reg_wdata[i]),
      .flag_q  (flags[i]),
      .mask_q  (masks[i]),
      .req     (reqs[i])
    );
  end

  assign per_irq = |reqs;

  irq_pend_stage u_pend (
    .clk     (clk),
    .rst     (rst),
    .req_in  (per_irq),
    .pend_set(wr_pctl & reg_wdata[PB_SET]),
    .pend_clr(wr_pctl & reg_wdata[PB_CLR]),
    .en_set  (wr_pctl & reg_wdata[PB_ESET]),
    .en_clr  (wr_pctl & reg_wdata[PB_ECLR]),
    .pend_q  (pend_q),
    .en_q    (en_q),
    .core_irq(core_irq)
  );

  function automatic logic [REG_W-1:0] widen(input logic [N_SRC-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[N_SRC-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_FLAGS: reg_rdata <= widen(flags);
        A_MASK:  reg_rdata <= widen(masks);
        A_PCTL:  reg_rdata <= {{(REG_W-2){1'b0}}, en_q, pend_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (masks == '0) |-> !per_irq); // R5

  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (rst)
    (PAD_W == 0) || (reg_rdata >> N_SRC) == '0 || $past(reg_addr) == A_PCTL); // R10
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int N = 8;

  logic clk = 0;
  logic rst;
  logic [N-1:0] src_evt;
  logic reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic per_irq, core_irq;

  int checks = 0, errors = 0;

  irq_aggregator #(.N_SRC(N)) dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_irq(per_irq), .core_irq(core_irq)
  );

  always #5 clk = ~clk;

  // {addr, wdata, expected flags}
  localparam logic [42:0] VEC [8] = '{
    {3'd1, 32'h0000_0005, 8'h05},
    {3'd1, 32'h0000_00F0, 8'hF5},
    {3'd2, 32'h0000_0011, 8'hE4},
    {3'd2, 32'h0000_0000, 8'hE4},
    {3'd0, 32'h0000_00FF, 8'hE4},
    {3'd1, 32'h0000_0000, 8'hE4},
    {3'd2, 32'h0000_00FF, 8'h00},
    {3'd1, 32'hFFFF_FFFF, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1; src_evt = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R9 reset state
    chk("R9 rdata", reg_rdata, 32'h0);
    chk("R9 per_irq", {31'b0, per_irq}, 32'h0);
    chk("R9 core_irq", {31'b0, core_irq}, 32'h0);
    rd(3'd0, d); chk("R9 flags", d, 32'h0);
    rd(3'd4, d); chk("R9 pend/en", d, 32'h0);

    // R2 R3 R10 vector table
    foreach (VEC[k]) begin
      wr(VEC[k][42:40], VEC[k][39:8]);
      rd(3'd0, d);
      chk("R2/R3/R10 table", d, {24'b0, VEC[k][7:0]});
    end
    wr(3'd2, 32'hFF);

    // R1 hardware event sets and holds
    @(negedge clk); src_evt = 8'h08;
    @(negedge clk); src_evt = '0;
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R1 event latched", d, 32'h08);

    // R4 event beats clear
    @(negedge clk); src_evt = 8'h01; reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h09;
    @(negedge clk); src_evt = '0; reg_wr = 0; reg_wdata = '0;
    rd(3'd0, d); chk("R4 hw set wins", d, 32'h01);

    // R5 mask gating, raw readback
    chk("R5 unmasked no irq", {31'b0, per_irq}, 32'h0);
    wr(3'd3, 32'h02);
    chk("R5 mask miss", {31'b0, per_irq}, 32'h0);
    rd(3'd3, d); chk("R10 mask read", d, 32'h02);
    rd(3'd0, d); chk("R10 raw flags", d, 32'h01);
    rd(3'd4, d); chk("R6 no pend without req", d, 32'h0);
    wr(3'd2, 32'h01);

    // R6 R8 latency: event -> per_irq -> pend -> core_irq
    wr(3'd4, 32'h4);
    @(negedge clk); src_evt = 8'h02;
    @(negedge clk); src_evt = '0;
    chk("R5 per_irq high", {31'b0, per_irq}, 32'h1);
    chk("R6 core_irq not yet", {31'b0, core_irq}, 32'h0);
    @(negedge clk);
    chk("R6 R8 core_irq", {31'b0, core_irq}, 32'h1);

    // R7 clear while request high: drops one cycle, re-sets
    wr(3'd4, 32'h2);
    chk("R7 pend cleared", {31'b0, core_irq}, 32'h0);
    @(negedge clk);
    chk("R7 pend re-set", {31'b0, core_irq}, 32'h1);

    // R7 clear after request removed stays clear; set+clear -> clear
    wr(3'd2, 32'h02);
    wr(3'd4, 32'h3);
    @(negedge clk);
    chk("R7 clear wins over set", {31'b0, core_irq}, 32'h0);
    wr(3'd4, 32'h1);
    chk("R7 sw set pend", {31'b0, core_irq}, 32'h1);

    // R8 enable clear gates core_irq, set+clear -> clear
    wr(3'd4, 32'hC);
    chk("R8 enable cleared", {31'b0, core_irq}, 32'h0);
    rd(3'd4, d); chk("R8 pend kept", d, 32'h1);
    rd(3'd5, d); chk("R10 unused addr", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule